// File: doc/BRIEF.md
# Prioritized Nestable Interrupt Controller

This block collects interrupt events from up to 64 peripheral sources (44 by default) and decides which one, if any, the processor core should take next. Each source owns a pending flag, an enable bit and a 3-bit priority. A combinational arbiter picks the strongest enabled pending source. Its request reaches the core only when its priority beats the current 4-bit CPU priority level and no masking rule holds it back. The core then gets a 24-bit vector address from either the primary or the alternate vector table.

On acknowledge, the controller raises the CPU level to the winner's priority and pushes the old level onto a small stack. A return-from-interrupt pulse pops it back. Software can forbid nesting, which also freezes the CPU level against bus writes. Software can also open a masking window that holds back priorities 1 to 6 for a programmed number of retired instructions. Every register is a 16-bit word on a simple read/write bus, with combinational reads.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A one-cycle pulse on `src_pulse[i]` sets pending flag i on the next clock edge, whatever the enable bit holds. Flags read back at word address 0 + i/16, bit i%16.
- R2: Writing a word to a flag address clears each flag whose data bit is 1 and leaves flags under 0 bits alone. A source pulse in the same cycle as a clearing write leaves the flag set.
- R3: Priority of source i is at word 16 + i/4, bits [4*(i%4)+2 : 4*(i%4)]. Enables are at word 4 + i/16, bit i%16. A source with priority 0 or enable 0 never drives `irq_req`.
- R4: The winner is the enabled pending source with the highest priority, and the lowest index wins a tie. `irq_req` is high only when that priority is strictly greater than the CPU level (word 33, bits [3:0]).
- R5: With nesting disabled (word 32 bit 0) and at least one level pushed, `irq_req` stays low, whatever the priority.
- R6: While nesting is disabled, bus writes to the CPU level word are ignored. With nesting enabled, they take effect.
- R7: Writing N to word 34 loads a masking count that replaces any remaining count. Each `instr_retired` pulse decrements a nonzero count. While the count is nonzero, `mask_active` and word 32 bit 2 read 1, and winners of priority 6 or lower are held back. Priority 7 still passes. Word 34 reads the remaining count.
- R8: The vector address is base + 2*(8 + winner index). The base is 0x000004 for the primary table and 0x000084 for the alternate table, which is selected by word 32 bit 1. Source 0 therefore maps to 0x000014 (primary) or 0x000094 (alternate).
- R9: `irq_ack` while `irq_req` is high pushes the CPU level and loads the winner's priority. `irq_ret` pops the saved level. `irq_ack` while `irq_req` is low changes nothing.
- R10: When `irq_ack` and `irq_ret` are both high in one cycle, the return is served and the acknowledge is ignored.
- R11: After reset, all flags, enables, priorities, controls, the CPU level and the masking count are zero, and `irq_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_pulse | input | N_SRC | Per-source event strobes |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 6 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| irq_ack | input | 1 | Core takes the presented interrupt |
| irq_ret | input | 1 | Core returns from an interrupt |
| instr_retired | input | 1 | One pulse per retired instruction |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec_addr | output | 24 | Vector address of the current winner |
| cpu_level | output | 4 | Current CPU priority level |
| mask_active | output | 1 | Masking window open |

## Verification
The bench targets equal-priority ties, where a reversed scan would vector to the higher-numbered source. It checks the strict level comparison, where an off-by-one would present an interrupt at its own level. It checks a clear-write that coincides with a new event, where a design giving the clear precedence would drop the event. It checks priority 7 passing an open masking window, and a mid-window reload that a design adding to the count would overrun. It also covers a level write under disabled nesting, which a careless design would accept, and a simultaneous acknowledge and return, where a wrong order would leave the CPU level raised instead of restored.

// File: rtl/prio_irq_pkg.sv
// Package: shared constants for the prioritized interrupt controller.
// Assumes at most 64 sources and at most 16 priority words.
package prio_irq_pkg;
    localparam int ADDR_W    = 6;
    localparam int DATA_W    = 16;
    localparam int LVL_W     = 4;
    localparam int PRIO_W    = 3;
    localparam int IDX_W     = 6;
    localparam int VEC_W     = 24;

    // Register word map
    localparam int A_FLAG0   = 0;
    localparam int A_EN0     = 4;
    localparam int A_PRI0    = 16;
    localparam int A_CTRL    = 32;
    localparam int A_LVL     = 33;
    localparam int A_MASK    = 34;

    // Control word bit positions
    localparam int C_NEST_OFF = 0;
    localparam int C_ALT_TBL  = 1;
    localparam int C_MASK_ST  = 2;

    // Highest priority held back by the masking window
    localparam int MASK_CEIL  = 6;

    typedef struct packed {
        logic              valid;
        logic [PRIO_W-1:0] prio;
        logic [IDX_W-1:0]  idx;
    } win_t;
endpackage

// File: rtl/pic_regfile.sv
// Module: per-source flag, enable and priority storage with bus decode.
// Assumes N_SRC <= 64; flags are set by source pulses and cleared by
// write-one-to-clear; a set in the same cycle as a clear wins.
module pic_regfile
    import prio_irq_pkg::*;
#(
    parameter int N_SRC = 44
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [N_SRC-1:0]              src_pulse,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [DATA_W-1:0]             wdata,
    output logic [N_SRC-1:0]              flags,
    output logic [N_SRC-1:0]              enables,
    output logic [N_SRC-1:0][PRIO_W-1:0]  prio,
    output logic [DATA_W-1:0]             rdata,
    output logic                          hit
);
    localparam int PER_WORD = DATA_W;
    localparam int PRI_PER  = DATA_W / 4;

    genvar g;
    generate
        for (g = 0; g < N_SRC; g++) begin : g_src
            localparam int FW  = A_FLAG0 + g / PER_WORD;
            localparam int EW  = A_EN0 + g / PER_WORD;
            localparam int PW  = A_PRI0 + g / PRI_PER;
            localparam int BIT = g % PER_WORD;
            localparam int NIB = 4 * (g % PRI_PER);

            logic clr_hit;
            assign clr_hit = wr_en && (addr == ADDR_W'(FW)) && wdata[BIT];

            // Flag: set by the source, cleared by a one written to its bit
            always_ff @(posedge clk) begin
                if (!rst_n)
                    flags[g] <= 1'b0;
                else if (src_pulse[g])
                    flags[g] <= 1'b1;
                else if (clr_hit)
                    flags[g] <= 1'b0;
            end

            // Enable bit: plain read/write
            always_ff @(posedge clk) begin
                if (!rst_n)
                    enables[g] <= 1'b0;
                else if (wr_en && addr == ADDR_W'(EW))
                    enables[g] <= wdata[BIT];
            end

            // Priority field: plain read/write nibble
            always_ff @(posedge clk) begin
                if (!rst_n)
                    prio[g] <= '0;
                else if (wr_en && addr == ADDR_W'(PW))
                    prio[g] <= wdata[NIB +: PRIO_W];
            end
        end
    endgenerate

    // Read mux over the per-source words
    always_comb begin
        rdata = '0;
        hit   = 1'b0;
        for (int i = 0; i < N_SRC; i++) begin
            if (addr == ADDR_W'(A_FLAG0 + i / PER_WORD)) begin
                rdata[i % PER_WORD] = flags[i];
                hit = 1'b1;
            end
            if (addr == ADDR_W'(A_EN0 + i / PER_WORD)) begin
                rdata[i % PER_WORD] = enables[i];
                hit = 1'b1;
            end
            if (addr == ADDR_W'(A_PRI0 + i / PRI_PER)) begin
                rdata[4 * (i % PRI_PER) +: PRIO_W] = prio[i];
                hit = 1'b1;
            end
        end
    end
endmodule

// File: rtl/pic_arbiter.sv
// Module: combinational winner selection.
// Picks the highest nonzero priority among enabled pending sources;
// the ascending scan with a strict compare lets the lowest index win ties.
module pic_arbiter
    import prio_irq_pkg::*;
#(
    parameter int N_SRC = 44
) (
    input  logic [N_SRC-1:0]              flags,
    input  logic [N_SRC-1:0]              enables,
    input  logic [N_SRC-1:0][PRIO_W-1:0]  prio,
    output win_t                          win
);
    // Linear scan for the strongest eligible source
    always_comb begin
        logic [PRIO_W-1:0] best_p;
        logic [IDX_W-1:0]  best_i;
        best_p = '0;
        best_i = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (flags[i] && enables[i] && prio[i] > best_p) begin
                best_p = prio[i];
                best_i = IDX_W'(i);
            end
        end
        win.valid = (best_p != '0);
        win.prio  = best_p;
        win.idx   = best_i;
    end
endmodule

// File: rtl/pic_level_stack.sv
// Module: CPU priority level with a save stack for nesting.
// Assumes the caller only asserts take when the stack has room; a
// return with an empty stack is ignored; software writes honour lock.
module pic_level_stack
    import prio_irq_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         take,
    input  logic [PRIO_W-1:0]            take_prio,
    input  logic                         ret,
    input  logic                         sw_wr,
    input  logic [LVL_W-1:0]             sw_lvl,
    input  logic                         lock,
    output logic [LVL_W-1:0]             cpu_lvl,
    output logic [$clog2(DEPTH+1)-1:0]   depth,
    output logic                         full
);
    localparam int DEPTH_W = $clog2(DEPTH + 1);
    localparam int PTR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DEPTH-1:0][LVL_W-1:0] stk;

    assign full = (depth == DEPTH_W'(DEPTH));

    // Level update: return first, then acknowledge, then software write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_lvl <= '0;
            depth   <= '0;
            stk     <= '0;
        end else if (ret && depth != '0) begin
            cpu_lvl <= stk[PTR_W'(depth - 1'b1)];
            depth   <= depth - 1'b1;
        end else if (take) begin
            stk[PTR_W'(depth)] <= cpu_lvl;
            cpu_lvl <= {1'b0, take_prio};
            depth   <= depth + 1'b1;
        end else if (sw_wr && !lock) begin
            cpu_lvl <= sw_lvl;
        end
    end
endmodule

// File: rtl/pic_mask_timer.sv
// Module: instruction-counted masking window.
// A load replaces the remaining count; each tick decrements a nonzero count.
module pic_mask_timer #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt,
    output logic             active
);
    // Countdown register
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (tick && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign active = (cnt != '0);
endmodule

// File: rtl/prio_irq_ctrl.sv
// Module: top of the prioritized nestable interrupt controller.
// Joins storage, arbiter, level stack and masking timer; gates the
// request with the level compare, nesting lock, mask window and stack room.
module prio_irq_ctrl
    import prio_irq_pkg::*;
#(
    parameter int          N_SRC     = 44,
    parameter int          DEPTH     = 8,
    parameter int          CNT_W     = 14,
    parameter int          RSV_SLOTS = 8,
    parameter logic [23:0] PRI_BASE  = 24'h000004,
    parameter logic [23:0] ALT_BASE  = 24'h000084
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_SRC-1:0]   src_pulse,
    input  logic               bus_wr,
    input  logic [5:0]         bus_addr,
    input  logic [15:0]        bus_wdata,
    output logic [15:0]        bus_rdata,
    input  logic               irq_ack,
    input  logic               irq_ret,
    input  logic               instr_retired,
    output logic               irq_req,
    output logic [23:0]        irq_vec_addr,
    output logic [3:0]         cpu_level,
    output logic               mask_active
);
    localparam int DEPTH_W = $clog2(DEPTH + 1);

    logic [N_SRC-1:0]             flags;
    logic [N_SRC-1:0]             enables;
    logic [N_SRC-1:0][PRIO_W-1:0] prio;
    logic [DATA_W-1:0]            rf_rdata;
    logic                         rf_hit;
    win_t                         win;
    logic [PRIO_W-1:0]            win_prio;
    logic                         nest_off;
    logic                         alt_sel;
    logic [DEPTH_W-1:0]           depth;
    logic                         full;
    logic [CNT_W-1:0]             mask_cnt;
    logic                         take;

    pic_regfile #(.N_SRC(N_SRC)) u_rf (
        .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse),
        .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
        .flags(flags), .enables(enables), .prio(prio),
        .rdata(rf_rdata), .hit(rf_hit)
    );

    pic_arbiter #(.N_SRC(N_SRC)) u_arb (
        .flags(flags), .enables(enables), .prio(prio), .win(win)
    );

    assign win_prio = win.prio;

    // Control word: nesting disable and table select
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nest_off <= 1'b0;
            alt_sel  <= 1'b0;
        end else if (bus_wr && bus_addr == ADDR_W'(A_CTRL)) begin
            nest_off <= bus_wdata[C_NEST_OFF];
            alt_sel  <= bus_wdata[C_ALT_TBL];
        end
    end

    pic_mask_timer #(.CNT_W(CNT_W)) u_mask (
        .clk(clk), .rst_n(rst_n),
        .load(bus_wr && bus_addr == ADDR_W'(A_MASK)),
        .load_val(bus_wdata[CNT_W-1:0]),
        .tick(instr_retired), .cnt(mask_cnt), .active(mask_active)
    );

    // Request gating
    always_comb begin
        logic above, nest_blk, mask_blk;
        above    = {1'b0, win.prio} > cpu_level;
        nest_blk = nest_off && (depth != '0);
        mask_blk = mask_active && (win.prio <= PRIO_W'(MASK_CEIL));
        irq_req  = win.valid && above && !nest_blk && !mask_blk && !full;
    end

    assign take = irq_ack && irq_req && !irq_ret;

    pic_level_stack #(.DEPTH(DEPTH)) u_lvl (
        .clk(clk), .rst_n(rst_n), .take(take), .take_prio(win.prio),
        .ret(irq_ret), .sw_wr(bus_wr && bus_addr == ADDR_W'(A_LVL)),
        .sw_lvl(bus_wdata[LVL_W-1:0]), .lock(nest_off),
        .cpu_lvl(cpu_level), .depth(depth), .full(full)
    );

    // Vector address from the selected table
    always_comb begin
        logic [VEC_W-1:0] base;
        base = alt_sel ? ALT_BASE : PRI_BASE;
        irq_vec_addr = base + (VEC_W'(RSV_SLOTS) + VEC_W'(win.idx)) * VEC_W'(2);
    end

    // Bus read mux
    always_comb begin
        bus_rdata = '0;
        if (rf_hit)
            bus_rdata = rf_rdata;
        else if (bus_addr == ADDR_W'(A_CTRL)) begin
            bus_rdata[C_NEST_OFF] = nest_off;
            bus_rdata[C_ALT_TBL]  = alt_sel;
            bus_rdata[C_MASK_ST]  = mask_active;
        end else if (bus_addr == ADDR_W'(A_LVL))
            bus_rdata = DATA_W'(cpu_level);
        else if (bus_addr == ADDR_W'(A_MASK))
            bus_rdata = DATA_W'(mask_cnt);
    end
endmodule

// File: rtl/pic_checker.sv
// Module: protocol checker bound to prio_irq_ctrl.
// Relates the arbiter result, level stack, control bits and mask timer.
module pic_checker
    import prio_irq_pkg::*;
#(
    parameter int DEPTH_W = 4,
    parameter int CNT_W   = 14
) (
    input logic               clk,
    input logic               rst_n,
    input logic               irq_req,
    input logic               irq_ack,
    input logic               irq_ret,
    input logic               instr_retired,
    input logic               bus_wr,
    input logic [5:0]         bus_addr,
    input logic [PRIO_W-1:0]  win_prio,
    input logic [3:0]         cpu_level,
    input logic [DEPTH_W-1:0] depth,
    input logic               nest_off,
    input logic               mask_active,
    input logic [CNT_W-1:0]   mask_cnt
);
    // R3: a request never comes from a priority-0 winner
    a_r3_no_zero_prio: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> win_prio != '0);

    // R4: request only above the CPU level
    a_r4_above_level: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> {1'b0, win_prio} > cpu_level);

    // R5: no nesting while disabled
    a_r5_no_nesting: assert property (@(posedge clk) disable iff (!rst_n)
        (nest_off && depth != '0) |-> !irq_req);

    // R6: level frozen while nesting is disabled and the core is idle
    a_r6_level_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (nest_off && !irq_ack && !irq_ret) |=> $stable(cpu_level));

    // R7: mask window holds back priorities 6 and lower
    a_r7_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_active && win_prio <= PRIO_W'(MASK_CEIL)) |-> !irq_req);

    // R7: each retired instruction takes one off an open window
    a_r7_mask_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_cnt != '0 && instr_retired && !(bus_wr && bus_addr == 6'(A_MASK)))
        |=> mask_cnt == $past(mask_cnt) - 1'b1);

    // R9: an accepted acknowledge loads the winner's priority
    a_r9_ack_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_ack && !irq_ret) |=> cpu_level == {1'b0, $past(win_prio)});
endmodule

bind prio_irq_ctrl pic_checker #(.DEPTH_W(DEPTH_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_ack(irq_ack),
    .irq_ret(irq_ret), .instr_retired(instr_retired), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .win_prio(win_prio), .cpu_level(cpu_level),
    .depth(depth), .nest_off(nest_off), .mask_active(mask_active),
    .mask_cnt(mask_cnt)
);

// File: tb/prio_irq_ctrl_tb.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb;
    localparam int N = 44;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] src_pulse = '0;
    logic         bus_wr = 1'b0;
    logic [5:0]   bus_addr = '0;
    logic [15:0]  bus_wdata = '0;
    logic [15:0]  bus_rdata;
    logic         irq_ack = 1'b0, irq_ret = 1'b0, instr_retired = 1'b0;
    logic         irq_req, mask_active;
    logic [23:0]  irq_vec_addr;
    logic [3:0]   cpu_level;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    prio_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_ack(irq_ack), .irq_ret(irq_ret), .instr_retired(instr_retired),
        .irq_req(irq_req), .irq_vec_addr(irq_vec_addr),
        .cpu_level(cpu_level), .mask_active(mask_active)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(int a, logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 6'(a); bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(int a, output logic [15:0] d);
        bus_addr = 6'(a);
        #1 d = bus_rdata;
    endtask

    task automatic pulse(int s);
        @(negedge clk);
        src_pulse[s] = 1'b1;
        @(negedge clk);
        src_pulse = '0;
    endtask

    task automatic core(logic a, logic r, logic t);
        @(negedge clk);
        irq_ack = a; irq_ret = r; instr_retired = t;
        @(negedge clk);
        irq_ack = 1'b0; irq_ret = 1'b0; instr_retired = 1'b0;
    endtask

    task automatic t_reset();
        logic [15:0] d;
        rd(33, d); check("R11 level", d, 0);
        rd(32, d); check("R11 ctrl", d, 0);
        rd(0, d);  check("R11 flags", d, 0);
        check("R11 req", irq_req, 0);
    endtask

    task automatic t_flags();
        logic [15:0] d;
        pulse(5);
        rd(0, d); check("R1 flag set while disabled", d[5], 1);
        check("R1 no req", irq_req, 0);
        wr(0, 16'h0000);
        rd(0, d); check("R2 zero write keeps flag", d[5], 1);
        wr(0, 16'h0020);
        rd(0, d); check("R2 one clears flag", d[5], 0);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 6'd0; bus_wdata = 16'h0020; src_pulse[5] = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; src_pulse = '0;
        rd(0, d); check("R2 set beats clear", d[5], 1);
        wr(0, 16'h0020);
    endtask

    task automatic t_prio();
        logic [15:0] d;
        wr(5, 16'h0010);
        pulse(20);
        check("R3 prio zero no req", irq_req, 0);
        wr(21, 16'h0003);
        rd(21, d); check("R3 prio readback", d, 16'h0003);
        #1 check("R4 req", irq_req, 1);
        check("R8 primary vector", irq_vec_addr, 24'h00003C);
        wr(5, 16'h4010); wr(23, 16'h0300); pulse(30);
        #1 check("R4 tie lowest index", irq_vec_addr, 24'h00003C);
        wr(6, 16'h0800); wr(26, 16'h5000); pulse(43);
        #1 check("R4 highest prio", irq_vec_addr, 24'h00006A);
        wr(33, 16'h0005);
        #1 check("R4 equal level blocks", irq_req, 0);
        wr(33, 16'h0004);
        #1 check("R4 lower level passes", irq_req, 1);
    endtask

    task automatic t_alt();
        wr(32, 16'h0002);
        #1 check("R8 alternate vector", irq_vec_addr, 24'h0000EA);
        wr(32, 16'h0000);
        #1 check("R8 back to primary", irq_vec_addr, 24'h00006A);
    endtask

    task automatic t_nest();
        logic [15:0] d;
        core(1, 0, 0);
        rd(33, d); check("R9 ack loads level", d, 5);
        check("R9 lower pending held", irq_req, 0);
        wr(4, 16'h0400); wr(18, 16'h0700); pulse(10);
        #1 check("R4 nested req", irq_req, 1);
        check("R8 nested vector", irq_vec_addr, 24'h000028);
        wr(32, 16'h0001);
        #1 check("R5 nesting off blocks", irq_req, 0);
        wr(33, 16'h0000);
        rd(33, d); check("R6 level write ignored", d, 5);
        core(0, 1, 0);
        rd(33, d); check("R9 ret restores", d, 4);
        check("R5 depth zero allows req", irq_req, 1);
        wr(32, 16'h0000);
        wr(33, 16'h0000);
        rd(33, d); check("R6 level write accepted", d, 0);
    endtask

    task automatic t_mask();
        logic [15:0] d;
        wr(0, 16'h0400);
        wr(34, 16'h0003);
        #1 check("R7 mask_active", mask_active, 1);
        rd(32, d); check("R7 status bit", d[2], 1);
        check("R7 prio5 held", irq_req, 0);
        pulse(10);
        #1 check("R7 prio7 passes", irq_req, 1);
        wr(0, 16'h0400);
        core(0, 0, 1);
        rd(34, d); check("R7 decrement", d, 2);
        wr(34, 16'h0005);
        rd(34, d); check("R7 reload replaces", d, 5);
        for (int k = 0; k < 4; k++) core(0, 0, 1);
        #1 check("R7 still open", mask_active, 1);
        check("R7 still held", irq_req, 0);
        core(0, 0, 1);
        #1 check("R7 window closed", mask_active, 0);
        check("R7 req resumes", irq_req, 1);
    endtask

    task automatic t_ack_ret();
        logic [15:0] d;
        core(1, 0, 0);
        rd(33, d); check("R9 level 5", d, 5);
        pulse(10);
        #1 check("R10 req before", irq_req, 1);
        core(1, 1, 0);
        rd(33, d); check("R10 ret wins over ack", d, 0);
        wr(0, 16'hFFFF); wr(1, 16'hFFFF); wr(2, 16'hFFFF);
        #1 check("R9 idle", irq_req, 0);
        core(1, 0, 0);
        rd(33, d); check("R9 ack without req ignored", d, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_flags();
        t_prio();
        t_alt();
        t_nest();
        t_mask();
        t_ack_ret();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule